// File: doc/BRIEF.md
# Vector Configuration State Unit

This block keeps the vector configuration state of a vector coprocessor: the type register, the active vector length and the two-bit vector context status. A configuration request brings in a raw type word and an application vector length (AVL). The unit checks the type word, derives the maximum vector length (VLMAX) from the element width, the register-group multiplier and the hardware vector length, and then loads either the legal configuration or the illegal marker.

The context status can be written directly by privileged software through a separate port. While the status is Off, the vector unit is disabled. Any configuration request or vector CSR access in that state raises an illegal-instruction flag in the same cycle and leaves all state untouched. The raw type readback is laid out for a register width of 32 or 64 bits, with the illegal marker in the top bit.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, the type readback holds only bit XLEN-1 set, vl is 0, the context status is Off (0) and the illegal-instruction flag is low.
- R2: After a legal request, the type readback equals the request's bits [7:0] (multiplier code [2:0], width code [5:3], tail-agnostic bit 6, mask-agnostic bit 7), with every higher bit zero.
- R3: After a legal request, vl equals the smaller of AVL and VLMAX. VLMAX = VLEN*LMUL/SEW, where multiplier codes 000/001/010/011 give LMUL 1/2/4/8, codes 101/110/111 give 1/8, 1/4 and 1/2, and SEW = 8 << width code.
- R4: Multiplier code 100, or a width code of 100 or above, makes the request illegal.
- R5: Any nonzero bit from bit 8 up to bit XLEN-1 of the type word makes the request illegal.
- R6: A SEW larger than the ELEN parameter makes the request illegal.
- R7: A legal-looking configuration whose VLMAX is 0 is illegal.
- R8: An illegal request leaves the type readback with only bit XLEN-1 set and vl at 0.
- R9: While the status is Off (0), a configuration request or CSR access raises the illegal-instruction flag in that same cycle, and vl, type and status stay unchanged.
- R10: A configuration request accepted while the status is not Off moves the status to Dirty (3) on the next edge.
- R11: A direct status write loads the new status on the next edge. It wins over the Dirty update when both happen in the same cycle.
- R12: With XLEN = 32, the illegal marker sits at bit 31 and the upper-bit check covers bits [31:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgValid | input | 1 | Configuration request strobe |
| cfgType | input | XLEN | Raw type word of the request |
| cfgAvl | input | XLEN | Application vector length |
| csrAccess | input | 1 | A vector CSR access is being attempted |
| stWrEn | input | 1 | Direct context status write |
| stWrData | input | 2 | New context status value |
| vtypeRaw | output | XLEN | Raw type register readback |
| vlOut | output | XLEN | Current vector length |
| ctxStatus | output | 2 | Context status: 0 Off, 1 Initial, 2 Clean, 3 Dirty |
| illegalInstr | output | 1 | Request or access attempted while Off |

## Verification
The bench targets the boundaries of the VLMAX computation. These include AVL above and below VLMAX, the largest integer multiplier, a fractional group that yields exactly one element, and one that yields none. A design that shifts the wrong way for fractional codes would return a wrong vl or accept a zero-length group. Each reserved code, a stray upper bit, and a width above ELEN are each applied alone, so that a missed check shows up as a legal type readback instead of the marker. The Off state is probed with both a request and a CSR access, and a status write is made in the same cycle as a request. A unit that updated state while disabled, or let Dirty override the direct write, would differ at the ports. A second instance at XLEN 32 catches a marker placed at a fixed bit position.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef enum logic [1:0] {
    CTX_OFF   = 2'd0,
    CTX_INIT  = 2'd1,
    CTX_CLEAN = 2'd2,
    CTX_DIRTY = 2'd3
  } ctx_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWrite;    // load type/vl this cycle
    logic statusLoad;  // take the direct status value
    logic markDirty;   // move status to Dirty
  } vcfg_strb_t;

  localparam int unsigned LMUL_W = 3;
  localparam int unsigned SEWC_W = 3;
  localparam int unsigned FIELD_W = 8;

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64
) (
  input  logic [XLEN-1:0] cfgType,
  output logic            typeLegal,
  output logic [XLEN-1:0] vlmax
);
  localparam int unsigned WIDE = $clog2(VLEN) + 4;

  logic [LMUL_W-1:0] lmulCode;
  logic [SEWC_W-1:0] sewCode;
  logic              upperDirty;
  logic              lmulReserved;
  logic              sewReserved;
  logic              sewTooWide;
  logic [1:0]        upShift;
  logic [2:0]        downShift;
  logic [WIDE-1:0]   scaled;
  logic [WIDE-1:0]   quot;
  logic [31:0]       sewBits;

  assign lmulCode   = cfgType[2:0];
  assign sewCode    = cfgType[5:3];
  assign upperDirty = |cfgType[XLEN-1:FIELD_W];

  assign lmulReserved = (lmulCode == 3'b100);
  assign sewReserved  = sewCode[2];

  always_comb begin
    sewBits    = 32'd8 << sewCode[1:0];
    sewTooWide = (sewBits > ELEN);
  end

  // integer group widens, fractional group narrows
  always_comb begin
    if (lmulCode[2]) begin
      upShift   = 2'd0;
      downShift = 3'd4 - {1'b0, lmulCode[1:0]};
    end else begin
      upShift   = lmulCode[1:0];
      downShift = 3'd0;
    end
    scaled = WIDE'(VLEN) << upShift;
    quot   = scaled >> (4'd3 + {2'b00, sewCode[1:0]} + {1'b0, downShift});
  end

  assign vlmax = XLEN'(quot);

  assign typeLegal = !upperDirty && !lmulReserved && !sewReserved &&
                     !sewTooWide && (quot != '0);

endmodule

// File: rtl/vcfg_ctrl.sv
module vcfg_ctrl
  import vcfg_pkg::*;
(
  input  logic       cfgValid,
  input  logic       csrAccess,
  input  logic       stWrEn,
  input  logic [1:0] ctxStatus,
  output vcfg_strb_t strb,
  output logic       illegalInstr
);
  logic unitOff;

  assign unitOff = (ctx_e'(ctxStatus) == CTX_OFF);

  always_comb begin
    strb            = '0;
    strb.cfgWrite   = cfgValid && !unitOff;
    strb.statusLoad = stWrEn;
    strb.markDirty  = cfgValid && !unitOff && !stWrEn;
  end

  assign illegalInstr = unitOff && (cfgValid || csrAccess);

endmodule

// File: rtl/vcfg_dpath.sv
module vcfg_dpath
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  vcfg_strb_t      strb,
  input  logic [XLEN-1:0] cfgType,
  input  logic [XLEN-1:0] cfgAvl,
  input  logic [1:0]      stWrData,
  output logic [XLEN-1:0] vtypeRaw,
  output logic [XLEN-1:0] vlOut,
  output logic [1:0]      ctxStatus
);
  localparam logic [XLEN-1:0] ILL_MARK = {1'b1, {(XLEN-1){1'b0}}};

  logic            typeLegal;
  logic [XLEN-1:0] vlmax;
  logic [XLEN-1:0] vlNext;
  logic [XLEN-1:0] vtypeNext;
  logic [XLEN-1:0] vtypeQ;
  logic [XLEN-1:0] vlQ;
  logic [1:0]      statusQ;

  vcfg_decode #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) dec_i (
    .cfgType  (cfgType),
    .typeLegal(typeLegal),
    .vlmax    (vlmax)
  );

  always_comb begin
    if (typeLegal) begin
      vtypeNext = {{(XLEN-FIELD_W){1'b0}}, cfgType[FIELD_W-1:0]};
      vlNext    = (cfgAvl < vlmax) ? cfgAvl : vlmax;
    end else begin
      vtypeNext = ILL_MARK;
      vlNext    = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vtypeQ <= ILL_MARK;
      vlQ    <= '0;
    end else if (strb.cfgWrite) begin
      vtypeQ <= vtypeNext;
      vlQ    <= vlNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                statusQ <= CTX_OFF;
    else if (strb.statusLoad) statusQ <= stWrData;
    else if (strb.markDirty)  statusQ <= CTX_DIRTY;
  end

  assign vtypeRaw  = vtypeQ;
  assign vlOut     = vlQ;
  assign ctxStatus = statusQ;

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgValid,
  input  logic [XLEN-1:0] cfgType,
  input  logic [XLEN-1:0] cfgAvl,
  input  logic            csrAccess,
  input  logic            stWrEn,
  input  logic [1:0]      stWrData,
  output logic [XLEN-1:0] vtypeRaw,
  output logic [XLEN-1:0] vlOut,
  output logic [1:0]      ctxStatus,
  output logic            illegalInstr
);
  vcfg_strb_t strb;

  vcfg_ctrl ctrl_i (
    .cfgValid    (cfgValid),
    .csrAccess   (csrAccess),
    .stWrEn      (stWrEn),
    .ctxStatus   (ctxStatus),
    .strb        (strb),
    .illegalInstr(illegalInstr)
  );

  vcfg_dpath #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgType  (cfgType),
    .cfgAvl   (cfgAvl),
    .stWrData (stWrData),
    .vtypeRaw (vtypeRaw),
    .vlOut    (vlOut),
    .ctxStatus(ctxStatus)
  );

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLEN = 128
) (
  input logic            clk,
  input logic            rstN,
  input logic            cfgValid,
  input logic            csrAccess,
  input logic            stWrEn,
  input logic [1:0]      stWrData,
  input logic [XLEN-1:0] vtypeRaw,
  input logic [XLEN-1:0] vlOut,
  input logic [1:0]      ctxStatus,
  input logic            illegalInstr
);
  // R8
  ill_clears_vl_chk: assert property (@(posedge clk) disable iff (!rstN)
    vtypeRaw[XLEN-1] |-> (vlOut == '0));

  // R2
  legal_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vtypeRaw[XLEN-1] |-> (vtypeRaw[XLEN-2:8] == '0));

  // R3
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    vlOut <= XLEN'(VLEN));

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctxStatus == 2'd0 && !stWrEn) |=>
      ($stable(vtypeRaw) && $stable(vlOut) && ctxStatus == 2'd0));

  // R9
  off_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalInstr |-> (ctxStatus == 2'd0 && (cfgValid || csrAccess)));

  // R10
  dirty_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && ctxStatus != 2'd0 && !stWrEn) |=> (ctxStatus == 2'd3));

  // R11
  status_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stWrEn |=> (ctxStatus == $past(stWrData)));

endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN), .VLEN(VLEN)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cfgValid    (cfgValid),
  .csrAccess   (csrAccess),
  .stWrEn      (stWrEn),
  .stWrData    (stWrData),
  .vtypeRaw    (vtypeRaw),
  .vlOut       (vlOut),
  .ctxStatus   (ctxStatus),
  .illegalInstr(illegalInstr)
);

// File: tb/vcfg_unit_tb_top.sv
module vcfg_unit_tb_top;
  localparam logic [63:0] ILL64 = 64'h8000_0000_0000_0000;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [63:0] tw;
    logic [63:0] avl;
    logic [63:0] vt;
    logic [63:0] vl;
  } vec_t;

  // dut_i: VLEN 128, ELEN 32
  localparam vec_t VEC [NVEC] = '{
    '{64'h00,  64'd5,   64'h00, 64'd5},    // e8 m1, vlmax 16
    '{64'h00,  64'd100, 64'h00, 64'd16},   // AVL clipped
    '{64'h03,  64'd200, 64'h03, 64'd128},  // e8 m8
    '{64'h10,  64'd10,  64'h10, 64'd4},    // e32 m1
    '{64'hC9,  64'd7,   64'hC9, 64'd7},    // e16 m2, both policy bits
    '{64'h17,  64'd9,   64'h17, 64'd2},    // e32 mf2
    '{64'h0D,  64'd3,   64'h0D, 64'd1},    // e16 mf8, one element
    '{64'h0D,  64'd0,   64'h0D, 64'd0},    // AVL zero
    '{64'h15,  64'd4,   ILL64,  64'd0},    // e32 mf8, zero elements
    '{64'h04,  64'd4,   ILL64,  64'd0},    // reserved multiplier
    '{64'h20,  64'd4,   ILL64,  64'd0},    // reserved width
    '{64'h18,  64'd4,   ILL64,  64'd0},    // e64 above ELEN
    '{64'h100, 64'd4,   ILL64,  64'd0},    // bit 8 set
    '{ILL64,   64'd4,   ILL64,  64'd0}     // top bit set
  };
  localparam string TAG [NVEC] = '{"R3", "R3", "R3", "R3", "R2", "R3", "R3", "R3",
                                   "R7", "R4", "R4", "R6", "R5", "R5"};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0;
  logic [63:0] cfgType = '0;
  logic [63:0] cfgAvl = '0;
  logic        csrAccess = 1'b0;
  logic        stWrEn = 1'b0;
  logic [1:0]  stWrData = '0;
  logic [63:0] vtypeRaw, vlOut;
  logic [1:0]  ctxStatus;
  logic        illegalInstr;

  logic        sCfgValid = 1'b0;
  logic [31:0] sCfgType = '0;
  logic [31:0] sCfgAvl = '0;
  logic        sStWrEn = 1'b0;
  logic [1:0]  sStWrData = '0;
  logic [31:0] sVtype, sVl;
  logic [1:0]  sStatus;
  logic        sIllegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vcfg_unit #(.XLEN(64), .VLEN(128), .ELEN(32)) dut_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgType(cfgType),
    .cfgAvl(cfgAvl), .csrAccess(csrAccess), .stWrEn(stWrEn), .stWrData(stWrData),
    .vtypeRaw(vtypeRaw), .vlOut(vlOut), .ctxStatus(ctxStatus),
    .illegalInstr(illegalInstr)
  );

  vcfg_unit #(.XLEN(32), .VLEN(64), .ELEN(64)) dut32_i (
    .clk(clk), .rstN(rstN), .cfgValid(sCfgValid), .cfgType(sCfgType),
    .cfgAvl(sCfgAvl), .csrAccess(1'b0), .stWrEn(sStWrEn), .stWrData(sStWrData),
    .vtypeRaw(sVtype), .vlOut(sVl), .ctxStatus(sStatus),
    .illegalInstr(sIllegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "vtype", vtypeRaw, ILL64);
    chk("R1", "vl", vlOut, 64'd0);
    chk("R1", "status", {62'd0, ctxStatus}, 64'd0);
    chk("R1", "flag", {63'd0, illegalInstr}, 64'd0);

    // R9 request while Off
    cfgValid = 1'b1; cfgType = 64'h00; cfgAvl = 64'd5;
    #1 chk("R9", "flag on request", {63'd0, illegalInstr}, 64'd1);
    @(negedge clk);
    cfgValid = 1'b0;
    chk("R9", "vtype held", vtypeRaw, ILL64);
    chk("R9", "vl held", vlOut, 64'd0);
    chk("R9", "status held", {62'd0, ctxStatus}, 64'd0);
    csrAccess = 1'b1;
    #1 chk("R9", "flag on csr", {63'd0, illegalInstr}, 64'd1);
    @(negedge clk);
    csrAccess = 1'b0;
    #1 chk("R9", "flag idle", {63'd0, illegalInstr}, 64'd0);

    // R11 direct status write
    stWrEn = 1'b1; stWrData = 2'd1;
    @(negedge clk);
    stWrEn = 1'b0;
    chk("R11", "status initial", {62'd0, ctxStatus}, 64'd1);

    for (int i = 0; i < NVEC; i++) begin
      stWrEn = 1'b1; stWrData = 2'd2;
      @(negedge clk);
      stWrEn = 1'b0;
      cfgValid = 1'b1; cfgType = VEC[i].tw; cfgAvl = VEC[i].avl;
      #1 chk("R9", "no flag when on", {63'd0, illegalInstr}, 64'd0);
      @(negedge clk);
      cfgValid = 1'b0;
      chk(TAG[i], (VEC[i].vt[63] ? "R8 vtype" : "vtype"), vtypeRaw, VEC[i].vt);
      chk(TAG[i], (VEC[i].vt[63] ? "R8 vl" : "vl"), vlOut, VEC[i].vl);
      chk("R10", "dirty", {62'd0, ctxStatus}, 64'd3);
    end

    // R11 priority over dirty
    stWrEn = 1'b1; stWrData = 2'd2;
    cfgValid = 1'b1; cfgType = 64'h10; cfgAvl = 64'd3;
    @(negedge clk);
    stWrEn = 1'b0; cfgValid = 1'b0;
    chk("R11", "write beats dirty", {62'd0, ctxStatus}, 64'd2);
    chk("R3", "vl same cycle", vlOut, 64'd3);

    // R9 turning off freezes state
    stWrEn = 1'b1; stWrData = 2'd0;
    @(negedge clk);
    stWrEn = 1'b0;
    cfgValid = 1'b1; cfgType = 64'h00; cfgAvl = 64'd9;
    @(negedge clk);
    cfgValid = 1'b0;
    chk("R9", "vl frozen", vlOut, 64'd3);
    chk("R9", "vtype frozen", vtypeRaw, 64'h10);

    // R12 XLEN 32 instance
    chk("R12", "reset vtype", {32'd0, sVtype}, 64'h8000_0000);
    sStWrEn = 1'b1; sStWrData = 2'd1;
    @(negedge clk);
    sStWrEn = 1'b0;
    sCfgValid = 1'b1; sCfgType = 32'h1B; sCfgAvl = 32'd3;
    @(negedge clk);
    chk("R12", "e64 m8 vtype", {32'd0, sVtype}, 64'h1B);
    chk("R12", "e64 m8 vl", {32'd0, sVl}, 64'd3);
    sCfgType = 32'h00; sCfgAvl = 32'd20;
    @(negedge clk);
    chk("R12", "e8 m1 vl", {32'd0, sVl}, 64'd8);
    sCfgType = 32'h8000_0000; sCfgAvl = 32'd2;
    @(negedge clk);
    chk("R12", "top bit vtype", {32'd0, sVtype}, 64'h8000_0000);
    chk("R12", "top bit vl", {32'd0, sVl}, 64'd0);
    sCfgType = 32'h0000_4000;
    @(negedge clk);
    sCfgValid = 1'b0;
    chk("R12", "bit 14 vtype", {32'd0, sVtype}, 64'h8000_0000);
    chk("R12", "status dirty", {62'd0, sStatus}, 64'd3);
    chk("R12", "no flag", {63'd0, sIllegal}, 64'd0);

    finishRun();
  end

endmodule